// File: doc/BRIEF.md
# Adaptive Cache Line Decay Controller

This controller decides when each line of a cache is idle enough to be switched off so that it stops leaking. One shared tick is made by dividing the clock by a tick interval. Every line keeps a small saturating count of the ticks seen since its last access. A line that stays idle long enough loses its supply enable and its valid bit. An access to the line clears its idle count. An access to a line that was switched off is flagged as a decay-induced miss, and the line is powered again.

In adaptive mode the block corrects its own aggressiveness. Right after a line decays it is marked as freshly decayed for one more decay period. A miss reported on a freshly decayed line shows that the decay came too early. The block collects these early misses over a window of ticks. At the end of each window it doubles the tick interval if any early miss arrived, and halves it if none did. The interval is kept between a floor and a ceiling. The arrays, the tag match and the refill path sit outside this block. They supply the access and miss indications, and they read the per-line enables.

Top module: `cache_decay_ctrl`

## Requirements
- R1: After reset every line is powered (`line_pwr_en` all ones), no line is valid (`line_valid` all zeros), `decay_miss` is 0 and `tick_interval` equals TICK_DEFAULT.
- R2: An access (`acc_valid` high, line number on `acc_idx`) makes bit `acc_idx` of both `line_pwr_en` and `line_valid` read 1 in the next cycle. It also restarts that line's idle count at zero.
- R3: `decay_tick` is high for exactly one cycle out of every `tick_interval` cycles. The first pulse comes in the TICK_DEFAULT-th cycle after reset.
- R4: A powered line that sees 2^CNT_W ticks with no access decays on the last of them: from the next cycle its bits in `line_pwr_en` and `line_valid` read 0.
- R5: An access in the same cycle as a tick restarts the idle count rather than advancing it. That line therefore survives three further ticks and decays on the fourth (with CNT_W = 2).
- R6: An access to a line whose `line_pwr_en` bit is 0 raises `decay_miss` for one cycle, in the cycle after the access. Accesses to powered lines never raise it.
- R7: A line counts as freshly decayed from the tick on which it decays until 2^CNT_W further ticks have passed. A miss (`miss_valid` high, line on `miss_idx`) is early only if its line is freshly decayed at that moment. Accessing a line ends its fresh state.
- R8: Every WIN_TICKS-th tick since reset closes an evaluation window. If `adapt_en` is 1 and at least one early miss arrived during the window, including that closing cycle, the interval doubles, limited to TICK_MAX.
- R9: If `adapt_en` is 1 at a window close and no early miss arrived during that window, the interval halves, limited to TICK_MIN.
- R10: While `adapt_en` is 0 the interval never changes. Early misses still clear at each window close, whatever the mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| adapt_en | input | 1 | Enables interval doubling and halving |
| acc_valid | input | 1 | An access to a line this cycle |
| acc_idx | input | IDX_W | Line number of the access |
| miss_valid | input | 1 | A cache miss this cycle |
| miss_idx | input | IDX_W | Line number of the miss |
| line_pwr_en | output | NUM_LINES | Supply enable per line, bit i for line i |
| line_valid | output | NUM_LINES | Valid bit per line, bit i for line i |
| decay_miss | output | 1 | Previous cycle's access hit a switched-off line |
| decay_tick | output | 1 | The shared idle tick |
| tick_interval | output | TICK_W | Current tick interval in cycles |

## Verification
A wrong idle count or fresh flag in one line shows up at the ports one tick too early or too late. It appears as the cycle in which that line's enable and valid bits fall, or as a doubling or halving decision that differs at the next window close. A wrong tick phase moves `decay_tick` at once. A wrong window count or a wrong early-miss latch changes `tick_interval` at the next window boundary. The reference model in the bench works out every line's state from tick numbers, not from counters. It compares all outputs on every clock, so a divergence is reported in the cycle it reaches a port.

// File: rtl/decay_pkg.sv
package decay_pkg;

    // Power state of one line
    typedef enum logic [1:0] {
        LN_LIVE      = 2'd0,  // powered, idle count running
        LN_FRESH_OFF = 2'd1,  // switched off within the last decay period
        LN_COLD_OFF  = 2'd2   // switched off for longer than a period
    } line_mode_e;

    // Interval decision at a window close
    typedef enum logic [1:0] {
        ADJ_HOLD   = 2'd0,
        ADJ_GROW   = 2'd1,
        ADJ_SHRINK = 2'd2
    } adj_e;

endpackage

// File: rtl/decay_line_cell.sv
module decay_line_cell
    import decay_pkg::*;
#(
    parameter int CNT_W = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic hit,
    output logic pwr_en,
    output logic valid,
    output logic recent
);

    localparam logic [CNT_W-1:0] CNT_TOP = '1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        line_mode_e       mode;
        logic             valid;
    } cell_t;

    cell_t cell_d, cell_q;

    always_comb begin
        cell_d = cell_q;
        if (hit) begin
            // an access wins over a coincident tick
            cell_d.cnt   = '0;
            cell_d.mode  = LN_LIVE;
            cell_d.valid = 1'b1;
        end else if (tick) begin
            case (cell_q.mode)
                LN_LIVE: begin
                    if (cell_q.cnt == CNT_TOP) begin
                        cell_d.cnt   = '0;
                        cell_d.mode  = LN_FRESH_OFF;
                        cell_d.valid = 1'b0;
                    end else begin
                        cell_d.cnt = cell_q.cnt + 1'b1;
                    end
                end
                LN_FRESH_OFF: begin
                    if (cell_q.cnt == CNT_TOP) begin
                        cell_d.cnt  = '0;
                        cell_d.mode = LN_COLD_OFF;
                    end else begin
                        cell_d.cnt = cell_q.cnt + 1'b1;
                    end
                end
                default: cell_d = cell_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cell_q <= '{cnt: '0, mode: LN_LIVE, valid: 1'b0};
        end else begin
            cell_q <= cell_d;
        end
    end

    assign pwr_en = (cell_q.mode == LN_LIVE);
    assign valid  = cell_q.valid;
    assign recent = (cell_q.mode == LN_FRESH_OFF);

endmodule

// File: rtl/decay_line_bank.sv
module decay_line_bank #(
    parameter int NUM_LINES = 64,
    parameter int CNT_W     = 2,
    localparam int IDX_W    = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick,
    input  logic                 acc_valid,
    input  logic [IDX_W-1:0]     acc_idx,
    output logic [NUM_LINES-1:0] pwr_en,
    output logic [NUM_LINES-1:0] valid,
    output logic [NUM_LINES-1:0] recent
);

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        logic hit;
        assign hit = acc_valid && (acc_idx == IDX_W'(g));

        decay_line_cell #(
            .CNT_W (CNT_W)
        ) u_cell (
            .clk    (clk),
            .rst_n  (rst_n),
            .tick   (tick),
            .hit    (hit),
            .pwr_en (pwr_en[g]),
            .valid  (valid[g]),
            .recent (recent[g])
        );
    end

endmodule

// File: rtl/decay_tick_gen.sv
module decay_tick_gen #(
    parameter int TICK_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TICK_W-1:0] interval,
    output logic              tick
);

    typedef struct packed {
        logic [TICK_W-1:0] phase;
    } tg_t;

    tg_t tg_d, tg_q;

    // interval only changes on a tick, when phase restarts, so
    // phase never runs past the new limit
    assign tick = (tg_q.phase == interval - 1'b1);

    always_comb begin
        tg_d = tg_q;
        if (tick) begin
            tg_d.phase = '0;
        end else begin
            tg_d.phase = tg_q.phase + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tg_q <= '{phase: '0};
        end else begin
            tg_q <= tg_d;
        end
    end

endmodule

// File: rtl/decay_adapt_ctrl.sv
module decay_adapt_ctrl
    import decay_pkg::*;
#(
    parameter int TICK_W       = 16,
    parameter int TICK_DEFAULT = 2500,
    parameter int TICK_MIN     = 625,
    parameter int TICK_MAX     = 40000,
    parameter int WIN_TICKS    = 16,
    localparam int WIN_W       = (WIN_TICKS > 1) ? $clog2(WIN_TICKS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              quick_miss,
    input  logic              adapt_en,
    output logic [TICK_W-1:0] interval
);

    localparam logic [TICK_W:0]    MAX_WIDE = (TICK_W+1)'(TICK_MAX);
    localparam logic [TICK_W-1:0]  MAX_N    = TICK_W'(TICK_MAX);
    localparam logic [TICK_W-1:0]  MIN_N    = TICK_W'(TICK_MIN);
    localparam logic [TICK_W-1:0]  DEF_N    = TICK_W'(TICK_DEFAULT);
    localparam logic [WIN_W-1:0]   WIN_LAST = WIN_W'(WIN_TICKS - 1);

    typedef struct packed {
        logic [TICK_W-1:0] interval;
        logic [WIN_W-1:0]  win;
        logic              seen;
    } ad_t;

    ad_t ad_d, ad_q;

    logic              seen_now;
    logic              closing;
    adj_e              decision;
    logic [TICK_W:0]   doubled;
    logic [TICK_W-1:0] halved;
    logic [TICK_W-1:0] grown;
    logic [TICK_W-1:0] shrunk;

    always_comb begin
        seen_now = ad_q.seen | quick_miss;
        closing  = tick && (ad_q.win == WIN_LAST);

        doubled = {ad_q.interval, 1'b0};
        halved  = ad_q.interval >> 1;
        grown   = (doubled > MAX_WIDE) ? MAX_N : doubled[TICK_W-1:0];
        shrunk  = (halved < MIN_N) ? MIN_N : halved;

        if (!closing || !adapt_en) begin
            decision = ADJ_HOLD;
        end else if (seen_now) begin
            decision = ADJ_GROW;
        end else begin
            decision = ADJ_SHRINK;
        end
    end

    always_comb begin
        ad_d      = ad_q;
        ad_d.seen = seen_now;
        if (tick) begin
            if (closing) begin
                ad_d.win  = '0;
                ad_d.seen = 1'b0;
            end else begin
                ad_d.win = ad_q.win + 1'b1;
            end
        end
        case (decision)
            ADJ_GROW:   ad_d.interval = grown;
            ADJ_SHRINK: ad_d.interval = shrunk;
            default:    ad_d.interval = ad_q.interval;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ad_q <= '{interval: DEF_N, win: '0, seen: 1'b0};
        end else begin
            ad_q <= ad_d;
        end
    end

    assign interval = ad_q.interval;

endmodule

// File: rtl/cache_decay_ctrl.sv
module cache_decay_ctrl #(
    parameter int NUM_LINES    = 64,
    parameter int CNT_W        = 2,
    parameter int TICK_W       = 16,
    parameter int TICK_DEFAULT = 2500,
    parameter int TICK_MIN     = 625,
    parameter int TICK_MAX     = 40000,
    parameter int WIN_TICKS    = 16,
    localparam int IDX_W       = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 adapt_en,
    input  logic                 acc_valid,
    input  logic [IDX_W-1:0]     acc_idx,
    input  logic                 miss_valid,
    input  logic [IDX_W-1:0]     miss_idx,
    output logic [NUM_LINES-1:0] line_pwr_en,
    output logic [NUM_LINES-1:0] line_valid,
    output logic                 decay_miss,
    output logic                 decay_tick,
    output logic [TICK_W-1:0]    tick_interval
);

    typedef struct packed {
        logic decay_miss;
    } top_t;

    top_t top_d, top_q;

    logic [NUM_LINES-1:0] line_recent;
    logic                 quick_miss;

    decay_tick_gen #(
        .TICK_W (TICK_W)
    ) u_tick (
        .clk      (clk),
        .rst_n    (rst_n),
        .interval (tick_interval),
        .tick     (decay_tick)
    );

    decay_line_bank #(
        .NUM_LINES (NUM_LINES),
        .CNT_W     (CNT_W)
    ) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (decay_tick),
        .acc_valid (acc_valid),
        .acc_idx   (acc_idx),
        .pwr_en    (line_pwr_en),
        .valid     (line_valid),
        .recent    (line_recent)
    );

    // early miss: the missing line was switched off within the last period
    assign quick_miss = miss_valid && line_recent[miss_idx];

    decay_adapt_ctrl #(
        .TICK_W       (TICK_W),
        .TICK_DEFAULT (TICK_DEFAULT),
        .TICK_MIN     (TICK_MIN),
        .TICK_MAX     (TICK_MAX),
        .WIN_TICKS    (WIN_TICKS)
    ) u_adapt (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (decay_tick),
        .quick_miss (quick_miss),
        .adapt_en   (adapt_en),
        .interval   (tick_interval)
    );

    always_comb begin
        top_d            = top_q;
        top_d.decay_miss = acc_valid && !line_pwr_en[acc_idx];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            top_q <= '{decay_miss: 1'b0};
        end else begin
            top_q <= top_d;
        end
    end

    assign decay_miss = top_q.decay_miss;

endmodule

// File: rtl/cache_decay_ctrl_chk.sv
module cache_decay_ctrl_chk #(
    parameter int NUM_LINES = 64,
    parameter int TICK_W    = 16,
    parameter int TICK_MIN  = 625,
    parameter int TICK_MAX  = 40000,
    localparam int IDX_W    = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 adapt_en,
    input logic                 acc_valid,
    input logic [IDX_W-1:0]     acc_idx,
    input logic [NUM_LINES-1:0] line_pwr_en,
    input logic [NUM_LINES-1:0] line_valid,
    input logic                 decay_miss,
    input logic                 decay_tick,
    input logic [TICK_W-1:0]    tick_interval
);

    logic [IDX_W-1:0] idx_q;
    always_ff @(posedge clk) idx_q <= acc_idx;

    // R2: an accessed line is powered and valid one cycle later
    a_r2_access_powers: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |=> (line_pwr_en[idx_q] && line_valid[idx_q]));

    // R4: a line never holds valid data while switched off
    a_r4_valid_needs_power: assert property (@(posedge clk) disable iff (!rst_n)
        (line_valid & ~line_pwr_en) == '0);

    // R6: a decay-induced miss always follows an access
    a_r6_miss_after_access: assert property (@(posedge clk) disable iff (!rst_n)
        decay_miss |-> $past(acc_valid));

    // R8: the interval stays inside its limits
    a_r8_interval_bounds: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_interval >= TICK_W'(TICK_MIN)) && (tick_interval <= TICK_W'(TICK_MAX)));

    // R9: the interval only moves on a tick
    a_r9_change_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_interval != $past(tick_interval)) |-> $past(decay_tick));

    // R10: no interval change while adaptation is off
    a_r10_hold_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(adapt_en) |-> $stable(tick_interval));

endmodule

bind cache_decay_ctrl cache_decay_ctrl_chk #(
    .NUM_LINES (NUM_LINES),
    .TICK_W    (TICK_W),
    .TICK_MIN  (TICK_MIN),
    .TICK_MAX  (TICK_MAX)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .adapt_en      (adapt_en),
    .acc_valid     (acc_valid),
    .acc_idx       (acc_idx),
    .line_pwr_en   (line_pwr_en),
    .line_valid    (line_valid),
    .decay_miss    (decay_miss),
    .decay_tick    (decay_tick),
    .tick_interval (tick_interval)
);

// File: tb/cache_decay_ctrl_tb.sv
module cache_decay_ctrl_tb;

    localparam int NL    = 64;
    localparam int CW    = 2;
    localparam int TW    = 16;
    localparam int TDEF  = 20;
    localparam int TMIN  = 5;
    localparam int TMAX  = 80;
    localparam int WIN   = 16;
    localparam int IW    = $clog2(NL);
    localparam int DTICK = 1 << CW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          adapt_en = 1'b0;
    logic          acc_valid = 1'b0;
    logic [IW-1:0] acc_idx = '0;
    logic          miss_valid = 1'b0;
    logic [IW-1:0] miss_idx = '0;
    logic [NL-1:0] line_pwr_en, line_valid;
    logic          decay_miss, decay_tick;
    logic [TW-1:0] tick_interval;

    always #10 clk = ~clk;

    cache_decay_ctrl #(
        .NUM_LINES (NL), .CNT_W (CW), .TICK_W (TW),
        .TICK_DEFAULT (TDEF), .TICK_MIN (TMIN), .TICK_MAX (TMAX),
        .WIN_TICKS (WIN)
    ) u_dut (
        .clk (clk), .rst_n (rst_n), .adapt_en (adapt_en),
        .acc_valid (acc_valid), .acc_idx (acc_idx),
        .miss_valid (miss_valid), .miss_idx (miss_idx),
        .line_pwr_en (line_pwr_en), .line_valid (line_valid),
        .decay_miss (decay_miss), .decay_tick (decay_tick),
        .tick_interval (tick_interval)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    task automatic cmp(string tag, logic [63:0] act, logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s at %0t: actual=%h expected=%h", tag, $time, act, exp);
        end
    endtask

    // Reference model: line state from tick numbers since the last access
    int m_ticks;
    int m_last[NL];
    bit m_ever[NL];
    int m_phase, m_int;
    bit m_seen, m_dmiss;

    function automatic bit m_live(int i);
        return (m_ticks - m_last[i]) < DTICK;
    endfunction

    function automatic bit m_fresh(int i);
        int d;
        d = m_ticks - m_last[i];
        return (d >= DTICK) && (d < 2 * DTICK);
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_ticks = 0; m_phase = 0; m_int = TDEF; m_seen = 0; m_dmiss = 0;
            for (int i = 0; i < NL; i++) begin m_last[i] = 0; m_ever[i] = 0; end
        end else begin
            bit tk, qm, dm, s;
            tk = (m_phase == m_int - 1);
            qm = miss_valid && m_fresh(int'(miss_idx));
            dm = acc_valid && !m_live(int'(acc_idx));
            if (tk) m_ticks++;
            if (acc_valid) begin
                m_last[acc_idx] = m_ticks;
                m_ever[acc_idx] = 1'b1;
            end
            s = m_seen | qm;
            if (tk && (m_ticks % WIN == 0)) begin
                if (adapt_en) begin
                    if (s) m_int = (2 * m_int > TMAX) ? TMAX : 2 * m_int;
                    else   m_int = (m_int / 2 < TMIN) ? TMIN : m_int / 2;
                end
                m_seen = 1'b0;
            end else begin
                m_seen = s;
            end
            m_phase = tk ? 0 : m_phase + 1;
            m_dmiss = dm;
        end
    end

    // Compare every output on every cycle, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            logic [63:0] ep, ev;
            ep = '0; ev = '0;
            for (int i = 0; i < NL; i++) begin
                ep[i] = m_live(i);
                ev[i] = m_ever[i] && m_live(i);
            end
            cmp("R2 R4 line_pwr_en", 64'(line_pwr_en), ep);
            cmp("R2 R4 line_valid", 64'(line_valid), ev);
            cmp("R6 decay_miss", 64'(decay_miss), 64'(m_dmiss));
            cmp("R3 decay_tick", 64'(decay_tick), 64'(m_phase == m_int - 1));
            cmp("R8 R9 R10 tick_interval", 64'(tick_interval), 64'(m_int));
        end
    end

    task automatic finish_run();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL R1 watchdog: actual=running expected=finished");
        finish_run();
    end

    task automatic random_cycles(int n, int acc_mod, bit always_miss);
        for (int c = 0; c < n; c++) begin
            @(negedge clk);
            acc_valid  = ($urandom % acc_mod) == 0;
            acc_idx    = IW'($urandom);
            miss_valid = always_miss ? 1'b1 : (($urandom % 3) == 0);
            miss_idx   = IW'($urandom);
        end
        @(negedge clk);
        acc_valid = 1'b0; miss_valid = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset values
        cmp("R1 reset line_pwr_en", 64'(line_pwr_en), {64{1'b1}});
        cmp("R1 reset line_valid", 64'(line_valid), 64'd0);
        cmp("R1 reset decay_miss", 64'(decay_miss), 64'd0);
        cmp("R1 reset tick_interval", 64'(tick_interval), 64'(TDEF));
        rst_n = 1'b1;

        // R10: random traffic with adaptation off
        random_cycles(1500, 4, 1'b0);
        cmp("R10 interval held while off", 64'(tick_interval), 64'(TDEF));

        // R5: access line 5 in a tick cycle
        do @(negedge clk); while (!decay_tick);
        acc_valid = 1'b1; acc_idx = IW'(5);
        @(negedge clk);
        acc_valid = 1'b0;
        repeat (3 * TDEF) @(negedge clk);
        cmp("R5 line 5 alive after three ticks", 64'(line_pwr_en[5]), 64'd1);
        repeat (TDEF) @(negedge clk);
        cmp("R4 line 5 off after fourth tick", 64'(line_pwr_en[5]), 64'd0);
        cmp("R4 line 5 invalid after decay", 64'(line_valid[5]), 64'd0);

        // R6: access to the switched-off line
        acc_valid = 1'b1; acc_idx = IW'(5);
        @(negedge clk);
        acc_valid = 1'b0;
        cmp("R6 decay_miss raised", 64'(decay_miss), 64'd1);
        cmp("R2 line 5 repowered", 64'(line_pwr_en[5]), 64'd1);
        cmp("R2 line 5 valid", 64'(line_valid[5]), 64'd1);
        @(negedge clk);
        cmp("R6 decay_miss single cycle", 64'(decay_miss), 64'd0);

        // R9: adaptation on, no misses
        adapt_en = 1'b1;
        repeat (2000) @(negedge clk);
        cmp("R9 interval at floor", 64'(tick_interval), 64'(TMIN));

        // R7 R8: frequent misses on freshly decayed lines
        random_cycles(4000, 4, 1'b1);
        cmp("R7 R8 interval at ceiling", 64'(tick_interval), 64'(TMAX));

        // R10: misses with adaptation off
        adapt_en = 1'b0;
        random_cycles(1500, 4, 1'b1);
        cmp("R10 interval held at ceiling", 64'(tick_interval), 64'(TMAX));

        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule